// File: doc/BRIEF.md
# Relay Channel Mode Controller

This block decides, cycle by cycle, whether each of eight low-side relay channels has its gate driven. Software programs a 16-bit control word through the serial slave. The word holds a 2-bit mode for every channel. A channel can be parked in standby, switched on, switched off with the load-check current applied, or made to follow one of four external input pins. A per-channel fault-off request from the diagnosis logic always wins and holds the gate low.

A limp-home input provides a fail-safe path that does not depend on software. While limp-home is high, the control word is held at its reset value and serial writes are dropped. Input pins 1 to 4 then drive outputs 1 to 4 directly, and outputs 5 to 8 stay off. Limp-home overrides the active-low reset pin. When it is released, the control word is reinitialised. The four input pins, limp-home and the reset pin all pass through a synchroniser before they are used. The block reports standby while the reset pin is held low. It reports sleep when software has parked every channel in standby.

Top module: `relay_mode_ctrl`

## Requirements
- R1: Channel n (1..8) takes its mode from control bits [2n-1:2n-2]. Mode codes: 00 standby, 01 follow pin, 10 on, 11 off with diagnosis current.
- R2: A channel in mode 00 has its gate enable low and its diagnosis-current enable low.
- R3: A channel in mode 10 has its gate enable high unless its fault-off request is high.
- R4: A channel in mode 11 has its gate enable low and its diagnosis-current enable high.
- R5: In mode 01, channels 1..4 copy input pins 1..4 and channels 5..8 copy pins 1..4 in the same order. A low or open pin gives gate off.
- R6: After power-on reset, or while the synchronised reset pin is low, the control word is 0xFFFF and writes are ignored. standby_o is high while the reset pin is low and limp-home is low.
- R7: While limp-home is high, the control word is 0xFFFF and writes are ignored. Gates 1..4 equal pins 1..4, gates 5..8 are low, every diagnosis current is off, and standby_o is low even when the reset pin is low.
- R8: When limp-home is released, the control word is 0xFFFF, so all gates are off and all diagnosis currents are on. A write in the release cycle is dropped.
- R9: sleep_o is high exactly when the control word is 0x0000 and limp-home is low.
- R10: A high fault-off request for a channel forces its gate enable low in every mode, limp-home included.
- R11: Gate enable and diagnosis-current enable are never both high for the same channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin_n | input | 1 | External reset pin, active low, synchronised |
| limp_pin | input | 1 | Limp-home request, active high, synchronised |
| in_pin | input | 4 | Direct control pins, synchronised |
| wr_en | input | 1 | Control word write strobe from the serial slave |
| wr_data | input | 16 | Control word to write |
| fault_off | input | 8 | Per-channel forced-off request from diagnosis |
| gate_en | output | 8 | Per-channel gate enable |
| diag_cur_en | output | 8 | Per-channel diagnosis-current enable |
| standby_o | output | 1 | Reset pin holds the device in standby |
| sleep_o | output | 1 | All channels programmed to standby |

## Verification
Random control words mix all four mode codes across the channels, so a swapped bit pair or a wrong code decode shows up as a gate or diagnosis mismatch on one channel. Random pin and fault patterns in follow mode separate the pin-to-channel mapping for the lower and upper four channels, and show whether the fault mask is applied after the mode decode. Directed sequences cover the remaining cases. Limp-home is raised during reset to show that it takes priority. Writes are issued during reset, during limp-home and on the release cycle to show that they are dropped. The all-standby word is written to show sleep entry and exit.

// File: rtl/relay_mode_pkg.sv
package relay_mode_pkg;

  typedef enum logic [1:0] {
    MODE_STBY   = 2'b00,
    MODE_FOLLOW = 2'b01,
    MODE_ON     = 2'b10,
    MODE_OFF    = 2'b11
  } ch_mode_e;

  // Gate demand of one channel from its mode and its assigned pin
  function automatic logic mode_gate(ch_mode_e m, logic pin);
    logic g;
    case (m)
      MODE_FOLLOW: g = pin;
      MODE_ON:     g = 1'b1;
      default:     g = 1'b0;
    endcase
    return g;
  endfunction

  // Load-check current is applied only in the explicit off mode
  function automatic logic mode_diag(ch_mode_e m);
    return (m == MODE_OFF);
  endfunction

  // Pin that a channel follows: channels wrap around the pin set
  function automatic int pin_of_chan(int ch, int npin);
    return ch % npin;
  endfunction

endpackage

// File: rtl/relay_in_sync.sv
module relay_in_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) stg[s] <= RST_VAL;
          else        stg[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) stg[s] <= RST_VAL;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/relay_ctrl_reg.sv
module relay_ctrl_reg #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          lh_s,
  input  logic          rst_s_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] ctrl_q,
  output logic          reinit,
  output logic          wr_taken
);
  localparam logic [CW-1:0] CTRL_RST = '1;

  logic lh_d;

  // Release of limp-home re-initialises the word once more
  logic lh_fall;
  assign lh_fall  = lh_d && !lh_s;
  assign reinit   = lh_s || !rst_s_n || lh_fall;
  assign wr_taken = wr_en && !reinit;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ctrl_q <= CTRL_RST;
      lh_d   <= 1'b0;
    end else begin
      lh_d <= lh_s;
      if (reinit)        ctrl_q <= CTRL_RST;
      else if (wr_taken) ctrl_q <= wr_data;
    end
  end
endmodule

// File: rtl/relay_chan_decode.sv
module relay_chan_decode
  import relay_mode_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int NPIN = 4
) (
  input  logic [2*NCH-1:0] ctrl_q,
  input  logic [NPIN-1:0]  pin_s,
  input  logic             lh_s,
  input  logic [NCH-1:0]   fault_off,
  output logic [NCH-1:0]   gate_en,
  output logic [NCH-1:0]   diag_cur_en,
  output logic [NCH-1:0]   gate_req
);
  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam int PIN = pin_of_chan(c, NPIN);
      ch_mode_e mode;
      logic     sw_gate;
      logic     lh_gate;
      assign mode    = ch_mode_e'(ctrl_q[2*c +: 2]);
      assign sw_gate = mode_gate(mode, pin_s[PIN]);
      if (c < NPIN) begin : g_routed
        assign lh_gate = pin_s[c];
      end else begin : g_unrouted
        assign lh_gate = 1'b0;
      end
      assign gate_req[c]    = lh_s ? lh_gate : sw_gate;
      assign gate_en[c]     = gate_req[c] && !fault_off[c];
      assign diag_cur_en[c] = !lh_s && mode_diag(mode);
    end
  endgenerate
endmodule

// File: rtl/relay_mode_ctrl.sv
module relay_mode_ctrl #(
  parameter int NCH         = 8,
  parameter int NPIN        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic                rst_pin_n,
  input  logic                limp_pin,
  input  logic [NPIN-1:0]     in_pin,
  input  logic                wr_en,
  input  logic [2*NCH-1:0]    wr_data,
  input  logic [NCH-1:0]      fault_off,
  output logic [NCH-1:0]      gate_en,
  output logic [NCH-1:0]      diag_cur_en,
  output logic                standby_o,
  output logic                sleep_o
);
  localparam int CW = 2 * NCH;
  localparam int SW = NPIN + 2;

  logic [SW-1:0]  raw_in;
  logic [SW-1:0]  syn_in;
  logic [NPIN-1:0] pin_s;
  logic           lh_s;
  logic           rst_s_n;
  logic [CW-1:0]  ctrl_q;
  logic           reinit;
  logic           wr_taken;
  logic [NCH-1:0] gate_req;

  assign raw_in  = {rst_pin_n, limp_pin, in_pin};
  assign pin_s   = syn_in[NPIN-1:0];
  assign lh_s    = syn_in[NPIN];
  assign rst_s_n = syn_in[NPIN+1];

  relay_in_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync (
    .clk(clk), .por_n(por_n), .d(raw_in), .q(syn_in)
  );

  relay_ctrl_reg #(.CW(CW)) u_reg (
    .clk(clk), .por_n(por_n), .lh_s(lh_s), .rst_s_n(rst_s_n),
    .wr_en(wr_en), .wr_data(wr_data), .ctrl_q(ctrl_q),
    .reinit(reinit), .wr_taken(wr_taken)
  );

  relay_chan_decode #(.NCH(NCH), .NPIN(NPIN)) u_dec (
    .ctrl_q(ctrl_q), .pin_s(pin_s), .lh_s(lh_s), .fault_off(fault_off),
    .gate_en(gate_en), .diag_cur_en(diag_cur_en), .gate_req(gate_req)
  );

  assign standby_o = !rst_s_n && !lh_s;
  assign sleep_o   = !lh_s && (ctrl_q == '0);
endmodule

// File: rtl/relay_mode_chk.sv
module relay_mode_chk #(
  parameter int NCH  = 8,
  parameter int NPIN = 4
) (
  input logic             clk,
  input logic             por_n,
  input logic             lh_s,
  input logic             rst_s_n,
  input logic             wr_en,
  input logic [2*NCH-1:0] ctrl_q,
  input logic [NCH-1:0]   fault_off,
  input logic [NCH-1:0]   gate_en,
  input logic [NCH-1:0]   diag_cur_en,
  input logic             standby_o,
  input logic             sleep_o
);
  // R6 / R7: reset or limp-home leaves the word at all ones
  a_r6_reinit_word: assert property (@(posedge clk) disable iff (!por_n)
    (lh_s || !rst_s_n) |=> (ctrl_q == '1));

  // R8: the cycle after limp-home drops, the word is still all ones
  a_r8_release_word: assert property (@(posedge clk) disable iff (!por_n)
    $fell(lh_s) |=> (ctrl_q == '1));

  // R7: upper channels stay off during limp-home, no diagnosis current
  a_r7_limp_upper_off: assert property (@(posedge clk) disable iff (!por_n)
    lh_s |-> (gate_en[NCH-1:NPIN] == '0) && (diag_cur_en == '0));

  // R10: a fault-off request always wins
  a_r10_fault_wins: assert property (@(posedge clk) disable iff (!por_n)
    (gate_en & fault_off) == '0);

  // R11: gate and diagnosis current are exclusive per channel
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!por_n)
    (gate_en & diag_cur_en) == '0);

  // R9: sleep only with an all-standby word outside limp-home
  a_r9_sleep_word: assert property (@(posedge clk) disable iff (!por_n)
    sleep_o |-> (ctrl_q == '0) && !lh_s);

  // R6: standby indicator never shows during limp-home
  a_r6_standby_lh: assert property (@(posedge clk) disable iff (!por_n)
    standby_o |-> !lh_s && !rst_s_n);

  // R7: limp-home holds the word even when a write arrives
  a_r7_write_drop: assert property (@(posedge clk) disable iff (!por_n)
    (lh_s && wr_en) |=> $stable(ctrl_q));
endmodule

bind relay_mode_ctrl relay_mode_chk #(.NCH(NCH), .NPIN(NPIN)) u_chk (
  .clk(clk), .por_n(por_n), .lh_s(lh_s), .rst_s_n(rst_s_n), .wr_en(wr_en),
  .ctrl_q(ctrl_q), .fault_off(fault_off), .gate_en(gate_en),
  .diag_cur_en(diag_cur_en), .standby_o(standby_o), .sleep_o(sleep_o)
);

// File: tb/sim_relay_mode_ctrl.sv
`timescale 1ns/1ps
module sim_relay_mode_ctrl;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        rst_pin_n = 1'b1;
  logic        limp_pin = 1'b0;
  logic [3:0]  in_pin = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [7:0]  fault_off = '0;
  logic [7:0]  gate_en, diag_cur_en;
  logic        standby_o, sleep_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] mdl = 16'hFFFF;

  always #2.5 clk = ~clk;

  relay_mode_ctrl u0 (
    .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .limp_pin(limp_pin),
    .in_pin(in_pin), .wr_en(wr_en), .wr_data(wr_data), .fault_off(fault_off),
    .gate_en(gate_en), .diag_cur_en(diag_cur_en),
    .standby_o(standby_o), .sleep_o(sleep_o)
  );

  // Expected gates: bit pair per channel, upper channels reuse pins 1..4
  function automatic logic [7:0] exp_gate(logic [15:0] w, logic [3:0] p,
                                          logic lh, logic [7:0] f);
    logic [7:0] g;
    for (int c = 0; c < 8; c++) begin
      logic hi, lo;
      hi = w[2*c+1]; lo = w[2*c];
      if (lh) g[c] = (c < 4) ? p[c] : 1'b0;
      else    g[c] = (hi & ~lo) | (~hi & lo & p[c & 3]);
    end
    return g & ~f;
  endfunction

  function automatic logic [7:0] exp_diag(logic [15:0] w, logic lh);
    logic [7:0] d;
    for (int c = 0; c < 8; c++) d[c] = !lh && w[2*c+1] && w[2*c];
    return d;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write(logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_all(string req);
    chk({req, " gate"}, gate_en, exp_gate(mdl, in_pin, limp_pin, fault_off));
    chk({req, " diag"}, diag_cur_en, exp_diag(mdl, limp_pin));
    chk({req, " standby"}, standby_o, !rst_pin_n && !limp_pin);
    chk({req, " sleep"}, sleep_o, !limp_pin && mdl == 16'h0000);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    settle();
    // R6: reset state all off, diagnosis current on
    check_all("R6 reset");

    // R3 R2 R4 R1: channel 1 on, channel 8 standby, rest off
    mdl = 16'h3FFE; write(mdl); settle();
    check_all("R1 R3 layout");
    chk("R2 ch8 standby diag", diag_cur_en[7], 1'b0);
    chk("R3 ch1 on", gate_en[0], 1'b1);

    // R5: all follow, walk pins
    mdl = 16'h5555; write(mdl);
    for (int p = 0; p < 16; p++) begin
      in_pin = 4'(p); settle();
      check_all("R5 follow");
    end

    // R10: all on with faults
    mdl = 16'hAAAA; write(mdl);
    fault_off = 8'hA5; settle(); check_all("R10 fault");
    fault_off = '0;

    // R9: all standby -> sleep, then leave
    mdl = 16'h0000; write(mdl); settle(); check_all("R9 sleep");
    mdl = 16'h0002; write(mdl); settle(); check_all("R9 wake");

    // R6: reset pin low, writes ignored
    rst_pin_n = 1'b0; mdl = 16'hFFFF; settle(); check_all("R6 rst low");
    write(16'h5555); settle(); check_all("R6 write ignored");

    // R7: limp-home during reset wins
    limp_pin = 1'b1; in_pin = 4'b1011; fault_off = 8'h02; settle();
    check_all("R7 limp in reset");
    fault_off = '0;
    rst_pin_n = 1'b1; write(16'hAAAA); in_pin = 4'b0110; settle();
    check_all("R7 limp write ignored");

    // R8: release with a write near the release cycle
    @(negedge clk); limp_pin = 1'b0;
    repeat (2) @(negedge clk);
    wr_en = 1'b1; wr_data = 16'h5555;
    @(negedge clk); wr_en = 1'b0;
    settle(); check_all("R8 release");

    // Random mix (R1..R5, R10, R11)
    for (int i = 0; i < 300; i++) begin
      mdl = 16'($urandom); write(mdl);
      in_pin = 4'($urandom); fault_off = 8'($urandom & $urandom);
      settle();
      check_all("R1 R5 R10 random");
      chk("R11 exclusive", gate_en & diag_cur_en, 8'h00);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule